// File: doc/BRIEF.md
# Dual-Input Gated Decimal Counter

This block is a single decade counter that holds a value from 0 to 9 and returns to 0 after 9. Two count-control inputs can advance it, and their edges have opposite polarity. A rising edge on `rise_in_i` counts only while `fall_in_i` is high. A falling edge on `fall_in_i` counts only while `rise_in_i` is low. The system can therefore use either line as the count stimulus and hold the other as a level enable. Both lines are asynchronous to the fast system clock `clk_i`. Each passes through a two-stage synchronizer, and the edge detector then compares the current synchronized sample with the one from the cycle before.

The counter is a state machine with ten named states, DIG0 to DIG9, and four transitions:
- ADVANCE moves from DIGn to DIGn+1 on a qualified event.
- WRAP moves from DIG9 to DIG0 on a qualified event and raises `wrap_o` for one cycle, so a second decade can be cascaded.
- HOLD keeps the state when no event qualifies.
- CLEAR forces DIG0 while the master reset is active.

The master reset `mr_i` asserts asynchronously and releases synchronously. While reset is active the edge history keeps tracking the inputs, so releasing reset produces no stray count.

Top module: `bcdc_gated_counter`

## Requirements
- R1: `digit_o` carries the count in binary, with bit 0 the least significant. The count only takes the values 0 to 9, and a qualified event in state 9 yields 0.
- R2: A 0-to-1 change of `rise_in_i` while `fall_in_i` is 1 advances the count by exactly one.
- R3: A 1-to-0 change of `fall_in_i` while `rise_in_i` is 0 advances the count by exactly one.
- R4: A 0-to-1 change of `rise_in_i` while `fall_in_i` is 0 leaves the count unchanged. So does a 1-to-0 change of `fall_in_i` while `rise_in_i` is 1, including when both lines change together.
- R5: A 1-to-0 change of `rise_in_i` and a 0-to-1 change of `fall_in_i` never change the count.
- R6: A qualifying input change shows on `digit_o` after the third rising edge of `clk_i` that follows it, and not after the second.
- R7: While `mr_i` is 1, `digit_o` is 0 and `wrap_o` is 0 without waiting for a clock edge, and input changes do not count.
- R8: Input changes made while `mr_i` is 1 cause no count after `mr_i` returns to 0.
- R9: `wrap_o` is 1 for exactly one clock cycle on each 9-to-0 transition, during the first cycle in which `digit_o` reads 0, and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for sampling and state |
| mr_i | input | 1 | Master reset, active high; asserts asynchronously |
| rise_in_i | input | 1 | Count input that acts on its rising edge, gated by `fall_in_i` high |
| fall_in_i | input | 1 | Count input that acts on its falling edge, gated by `rise_in_i` low |
| digit_o | output | 4 | Current decimal count, 0 to 9 |
| wrap_o | output | 1 | One-cycle pulse on the 9-to-0 wrap |

## Verification
The bench aims at gating mistakes by changing both inputs in the same cycle. A design that takes the gate level from the stale sample would count when the two lines change together. A bench-side model compares every vector against the expected count and the number of wrap pulses, and a design that counts on the wrong edge polarity fails there. Directed cases cover the following faults:
- a decade boundary that wraps at 15 or 10;
- a synchronizer one stage short, which shows a result after the second clock edge;
- a reset that waits for the clock;
- edge history cleared to a fixed value instead of tracking, which counts on reset release.

// File: rtl/bcdc_pkg.sv
package bcdc_pkg;
    localparam int DIGIT_W   = 4;
    localparam int SYNC_LEN  = 2;
    localparam int RST_LEN   = 2;

    typedef enum logic [DIGIT_W-1:0] {
        DIG0 = 4'd0, DIG1 = 4'd1, DIG2 = 4'd2, DIG3 = 4'd3, DIG4 = 4'd4,
        DIG5 = 4'd5, DIG6 = 4'd6, DIG7 = 4'd7, DIG8 = 4'd8, DIG9 = 4'd9
    } digit_e;
endpackage

// File: rtl/bcdc_sync.sv
module bcdc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i) chain_q <= d_i;
        end else begin : g_multi
            always_ff @(posedge clk_i) chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bcdc_rst_sync.sv
module bcdc_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic arst_i,
    output logic rst_o
);
    logic [STAGES-1:0] hold_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i or posedge arst_i) begin
                if (arst_i) hold_q <= 1'b1;
                else        hold_q <= 1'b0;
            end
        end else begin : g_multi
            always_ff @(posedge clk_i or posedge arst_i) begin
                if (arst_i) hold_q <= '1;
                else        hold_q <= {hold_q[STAGES-2:0], 1'b0};
            end
        end
    endgenerate

    assign rst_o = hold_q[STAGES-1];
endmodule

// File: rtl/bcdc_edge_qual.sv
module bcdc_edge_qual (
    input  logic clk_i,
    input  logic rise_s_i,
    input  logic fall_s_i,
    output logic step_o
);
    logic rise_prev_q;
    logic fall_prev_q;
    logic rise_evt;
    logic fall_evt;

    // History always tracks the synchronized lines, so reset release sees no stale edge.
    always_ff @(posedge clk_i) begin
        rise_prev_q <= rise_s_i;
        fall_prev_q <= fall_s_i;
    end

    always_comb begin
        rise_evt = rise_s_i & ~rise_prev_q & fall_s_i;
        fall_evt = ~fall_s_i & fall_prev_q & ~rise_s_i;
        step_o   = rise_evt | fall_evt;   // simultaneous events merge into one step
    end
endmodule

// File: rtl/bcdc_gated_counter.sv
module bcdc_gated_counter
    import bcdc_pkg::*;
(
    input  logic               clk_i,
    input  logic               mr_i,
    input  logic               rise_in_i,
    input  logic               fall_in_i,
    output logic [DIGIT_W-1:0] digit_o,
    output logic               wrap_o
);
    logic   rst_int;
    logic   rise_s;
    logic   fall_s;
    logic   step;
    logic   adv;
    digit_e state_q;
    digit_e state_d;
    logic   wrap_q;
    logic   wrap_d;

    bcdc_rst_sync #(.STAGES(RST_LEN)) u_rst (
        .clk_i (clk_i),
        .arst_i(mr_i),
        .rst_o (rst_int)
    );

    bcdc_sync #(.STAGES(SYNC_LEN)) u_sync_rise (
        .clk_i(clk_i),
        .d_i  (rise_in_i),
        .q_o  (rise_s)
    );

    bcdc_sync #(.STAGES(SYNC_LEN)) u_sync_fall (
        .clk_i(clk_i),
        .d_i  (fall_in_i),
        .q_o  (fall_s)
    );

    bcdc_edge_qual u_edge (
        .clk_i   (clk_i),
        .rise_s_i(rise_s),
        .fall_s_i(fall_s),
        .step_o  (step)
    );

    assign adv = step & ~rst_int;

    // Next-state: ADVANCE, WRAP or HOLD; CLEAR is the asynchronous reset.
    always_comb begin
        state_d = state_q;
        wrap_d  = 1'b0;
        if (adv) begin
            unique case (state_q)
                DIG0: state_d = DIG1;
                DIG1: state_d = DIG2;
                DIG2: state_d = DIG3;
                DIG3: state_d = DIG4;
                DIG4: state_d = DIG5;
                DIG5: state_d = DIG6;
                DIG6: state_d = DIG7;
                DIG7: state_d = DIG8;
                DIG8: state_d = DIG9;
                DIG9: begin
                    state_d = DIG0;
                    wrap_d  = 1'b1;
                end
                default: state_d = DIG0;   // recovery from any illegal code
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i or posedge rst_int) begin
        if (rst_int) state_q <= DIG0;
        else         state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk_i or posedge rst_int) begin
        if (rst_int) wrap_q <= 1'b0;
        else         wrap_q <= wrap_d;
    end

    assign digit_o = state_q;
    assign wrap_o  = wrap_q;
endmodule

// File: rtl/bcdc_gated_counter_chk.sv
module bcdc_gated_counter_chk (
    input logic       clk_i,
    input logic       mr_i,
    input logic       rst_int,
    input logic       rise_s,
    input logic       fall_s,
    input logic [3:0] digit_o,
    input logic       wrap_o
);
    AST_MR_CLEARS: assert property (@(posedge clk_i)
        mr_i |-> (digit_o == 4'd0 && !wrap_o)); // R7

    AST_DIGIT_RANGE: assert property (@(posedge clk_i) disable iff (rst_int)
        digit_o <= 4'd9); // R1

    AST_STEP_BY_ONE: assert property (@(posedge clk_i) disable iff (rst_int)
        !$stable(digit_o) |-> digit_o == (($past(digit_o) == 4'd9) ? 4'd0 : $past(digit_o) + 4'd1)); // R2

    AST_QUIET_HOLDS: assert property (@(posedge clk_i) disable iff (rst_int)
        ($stable(rise_s) && $stable(fall_s)) |=> $stable(digit_o)); // R5

    AST_WRAP_ON_ZERO: assert property (@(posedge clk_i) disable iff (rst_int)
        wrap_o |-> (digit_o == 4'd0 && $past(digit_o) == 4'd9)); // R9

    AST_WRAP_SINGLE: assert property (@(posedge clk_i) disable iff (rst_int)
        wrap_o |=> !wrap_o); // R9
endmodule

bind bcdc_gated_counter bcdc_gated_counter_chk u_chk (
    .clk_i  (clk_i),
    .mr_i   (mr_i),
    .rst_int(rst_int),
    .rise_s (rise_s),
    .fall_s (fall_s),
    .digit_o(digit_o),
    .wrap_o (wrap_o)
);

// File: tb/bcdc_gated_counter_tb.sv
module bcdc_gated_counter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 4;

    logic       clk_i = 1'b0;
    logic       mr_i;
    logic       rise_in_i;
    logic       fall_in_i;
    logic [3:0] digit_o;
    logic       wrap_o;

    int checks = 0;
    int fails  = 0;
    int exp_digit;
    int wraps_seen;
    logic done = 1'b0;

    bcdc_gated_counter u_dut (
        .clk_i    (clk_i),
        .mr_i     (mr_i),
        .rise_in_i(rise_in_i),
        .fall_in_i(fall_in_i),
        .digit_o  (digit_o),
        .wrap_o   (wrap_o)
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    function automatic int next_digit(input int d);
        return (d == 9) ? 0 : d + 1;
    endfunction

    function automatic logic qualifies(input logic a0, input logic b0,
                                       input logic a1, input logic b1);
        return (!a0 && a1 && b1) || (b0 && !b1 && !a1);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply one input pair at a negedge, hold it, count wrap pulses, check the result.
    task automatic apply(input logic a, input logic b, input string req);
        logic a0 = rise_in_i;
        logic b0 = fall_in_i;
        int   exp_wraps = 0;
        rise_in_i  = a;
        fall_in_i  = b;
        wraps_seen = 0;
        if (qualifies(a0, b0, a, b)) begin
            if (exp_digit == 9) exp_wraps = 1;
            exp_digit = next_digit(exp_digit);
        end
        for (int i = 0; i < HOLD; i++) begin
            @(posedge clk_i);
            @(negedge clk_i);
            if (wrap_o) wraps_seen++;
        end
        check(req, int'(digit_o), exp_digit);
        check({req, " R9 wrap"}, wraps_seen, exp_wraps);
    endtask

    task automatic pulse_reset();
        #2 mr_i = 1'b1;
        #1 check("R7 async clear", int'(digit_o), 0);
        check("R7 wrap low", int'(wrap_o), 0);
        @(negedge clk_i);
        // Edges during reset must not count now or after release.
        rise_in_i = ~rise_in_i;
        repeat (2) @(negedge clk_i);
        fall_in_i = ~fall_in_i;
        repeat (3) @(negedge clk_i);
        check("R7 held in reset", int'(digit_o), 0);
        mr_i = 1'b0;
        exp_digit = 0;
        repeat (HOLD + 1) @(negedge clk_i);
        check("R8 no count on release", int'(digit_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        mr_i = 1'b1;
        rise_in_i = 1'b0;
        fall_in_i = 1'b1;
        exp_digit = 0;
        repeat (4) @(negedge clk_i);
        check("R7 reset state", int'(digit_o), 0);
        mr_i = 1'b0;
        repeat (4) @(negedge clk_i);
        check("R1 idle after reset", int'(digit_o), 0);

        // R6 latency: rising rise_in_i with fall_in_i high.
        rise_in_i = 1'b1;
        @(posedge clk_i); @(posedge clk_i); @(negedge clk_i);
        check("R6 not after two edges", int'(digit_o), 0);
        @(posedge clk_i); @(negedge clk_i);
        check("R6 after third edge", int'(digit_o), 1);
        exp_digit = 1;
        repeat (2) @(negedge clk_i);

        apply(1'b0, 1'b1, "R5 falling rise_in");
        apply(1'b1, 1'b1, "R2 rising rise_in gated high");
        apply(1'b0, 1'b1, "R5 falling rise_in");
        apply(1'b0, 1'b0, "R3 falling fall_in gated low");
        apply(1'b0, 1'b1, "R5 rising fall_in");
        apply(1'b1, 1'b0, "R4 both change together");
        apply(1'b0, 1'b0, "R5 falling rise_in");
        apply(1'b1, 1'b0, "R4 rising rise_in gated low");
        apply(1'b1, 1'b1, "R5 rising fall_in");
        apply(1'b1, 1'b0, "R4 falling fall_in gated high");

        // R1 and R9: run through several decades with rise_in_i as stimulus.
        apply(1'b0, 1'b1, "R5 setup");
        for (int k = 0; k < 24; k++) begin
            apply(1'b1, 1'b1, "R1 R2 decade run");
            apply(1'b0, 1'b1, "R5 decade run");
        end
        // Same with fall_in_i as stimulus.
        apply(1'b0, 1'b0, "R3 setup");
        for (int k = 0; k < 12; k++) begin
            apply(1'b0, 1'b1, "R5 decade run b");
            apply(1'b0, 1'b0, "R1 R3 decade run b");
        end

        pulse_reset();

        for (int n = 0; n < 600; n++) begin
            logic a = 1'($urandom_range(0, 1));
            logic b = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 59) == 0) pulse_reset();
            else apply(a, b, "R2 R3 R4 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule